// File: doc/BRIEF.md
# Code Memory Read Protection Gate

This block sits between the code-memory read path and the bus. For each read request it decides whether internal flash data may be returned, and it puts the chosen data on the bus. A request carries three things: the address being read, the address of the instruction that issued the read, and an access kind. The kind is an opcode fetch, a table read, or a readback by an external programmer. The internal code region covers addresses below a parameterised size (16 KB by default, 0x0000 to 0x3FFF). Every higher address is external code space. The block takes both the internal flash byte and the external byte as inputs and selects one of them. It does not run flash programming and does not generate external bus cycles.

Two non-volatile option bits shape the policy: a security lock and a table-read restriction. Each bit starts in the erased state 1. A programming strobe can move a bit to 0. Only a full chip erase returns the bits to 1. Chip erase also sets a "flash blank" indication, which the first write of flash contents clears.

Each decision is registered. The response appears one clock after the request, together with a grant flag. A denied read drives all-ones data and raises a violation flag for that response cycle only.

Top module: `codeReadGate`

## Requirements
- R1: While reset is asserted and after it is released, `respValid`, `grant` and `violation` are 0, `dataOut` is all ones, `flashBlank` is 1, and both option bits are in the erased state 1.
- R2: An opcode fetch (`reqKind` = 2'b00) is always granted, whatever either option bit holds. The returned data is `intData` when `reqAddr` is below the internal region size (0x3FFF is internal) and `extData` otherwise (0x4000 is external).
- R3: While the lock bit is 1, a programmer readback (`reqKind` = 2'b10) is granted. It returns `intData` for internal addresses and `extData` for external addresses.
- R4: While the lock bit is 0, a programmer readback is denied at every address.
- R5: While the restriction bit is 0, a table read (`reqKind` = 2'b01) is denied when the issuing instruction (`srcAddr`) is external and the target is internal.
- R6: While the restriction bit is 0, a table read is granted when both the issuing instruction and the target are external, and it returns `extData`.
- R7: A table read whose issuing instruction is in the internal region is granted for internal and external targets, whatever the restriction bit holds. An issuing address of 0x3FFF counts as internal.
- R8: While the restriction bit is 1, every table read is granted.
- R9: A denied response, including any request with the reserved kind 2'b11, shows `grant` = 0 and `dataOut` all ones, with `violation` = 1 only in that response cycle.
- R10: A request with `reqValid` high produces a response exactly one clock later. A clock with no request produces `respValid` = 0 and `violation` = 0 in the next cycle.
- R11: `optWrLock` and `optWrRestrict` each clear their option bit to 0 from the next clock. Only `chipErase` returns both bits to 1, and `chipErase` wins over a write in the same clock.
- R12: `flashBlank` goes to 1 on `chipErase` and to 0 on `progWrite`. Erase wins when both are high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the erased option state |
| reqValid | input | 1 | A read request is present this cycle |
| reqKind | input | 2 | 00 fetch, 01 table read, 10 programmer readback, 11 reserved |
| reqAddr | input | ADDR_W | Code address being read |
| srcAddr | input | ADDR_W | Address of the instruction that issued the read |
| intData | input | DATA_W | Internal flash byte at reqAddr |
| extData | input | DATA_W | External memory byte at reqAddr |
| optWrLock | input | 1 | Program the lock bit to 0 |
| optWrRestrict | input | 1 | Program the table-read restriction bit to 0 |
| chipErase | input | 1 | Full chip erase: options to 1, flash marked blank |
| progWrite | input | 1 | Flash contents written; clears the blank indication |
| respValid | output | 1 | Response for the previous cycle's request |
| grant | output | 1 | Response read was permitted |
| violation | output | 1 | Response read was denied |
| dataOut | output | DATA_W | Data for the bus; all ones when denied or idle |
| flashBlank | output | 1 | Flash is in the erased state |

## Verification
The bench targets the region edge on both addresses. Target 0x3FFF against 0x4000 shows whether data is taken from the wrong source. Issuing address 0x3FFF shows whether an off-by-one compare wrongly denies an internal table read. It checks that table reads from inside the region pass once the restriction is set, so a design that looks only at the target address gets caught. It also checks that locking programmer readback leaves fetches untouched, so a design that gates every kind gets caught. Finally, it confirms that a deny followed by an idle cycle drops `violation`, and that chip erase overrides a simultaneous lock write. A sticky flag would fail the first check; a wrong priority would leave the part locked.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_TABLE = 2'b01,
    KIND_PROG  = 2'b10,
    KIND_RSVD  = 2'b11
  } reqKind_e;

  // Strobes from the policy control to the response datapath
  typedef struct packed {
    logic load;    // a request is being answered
    logic allow;   // the request is permitted
    logic selInt;  // target lies in the internal region
  } gateStrobe_t;

endpackage

// File: rtl/cpg_option_store.sv
module cpg_option_store (
  input  logic clk,
  input  logic rst_n,
  input  logic optWrLock,
  input  logic optWrRestrict,
  input  logic chipErase,
  input  logic progWrite,
  output logic lockBit,
  output logic restrictBit,
  output logic flashBlank
);

  // Cells behave as flash: programming only moves 1 -> 0, erase restores 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockBit     <= 1'b1;
      restrictBit <= 1'b1;
      flashBlank  <= 1'b1;
    end else if (chipErase) begin
      lockBit     <= 1'b1;
      restrictBit <= 1'b1;
      flashBlank  <= 1'b1;
    end else begin
      if (optWrLock)     lockBit     <= 1'b0;
      if (optWrRestrict) restrictBit <= 1'b0;
      if (progWrite)     flashBlank  <= 1'b0;
    end
  end

endmodule

// File: rtl/cpg_policy.sv
module cpg_policy
  import cpg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INT_BYTES = 16384
) (
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic              lockBit,
  input  logic              restrictBit,
  output gateStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] INT_LIMIT = ADDR_W'(INT_BYTES);

  logic     targetInt;
  logic     issuerInt;
  logic     allowRaw;
  reqKind_e kind;

  assign targetInt = (reqAddr < INT_LIMIT);
  assign issuerInt = (srcAddr < INT_LIMIT);
  assign kind      = reqKind_e'(reqKind);

  always_comb begin
    unique case (kind)
      KIND_FETCH: allowRaw = 1'b1;
      // restricted table reads from outside may not see internal code
      KIND_TABLE: allowRaw = restrictBit | issuerInt | ~targetInt;
      KIND_PROG:  allowRaw = lockBit;
      default:    allowRaw = 1'b0;
    endcase
  end

  always_comb begin
    strobe.load   = reqValid;
    strobe.allow  = reqValid & allowRaw;
    strobe.selInt = targetInt;
  end

endmodule

// File: rtl/cpg_datapath.sv
module cpg_datapath
  import cpg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gateStrobe_t       strobe,
  input  logic [DATA_W-1:0] intData,
  input  logic [DATA_W-1:0] extData,
  output logic              respValid,
  output logic              grant,
  output logic              violation,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] picked;

  assign picked = strobe.selInt ? intData : extData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      grant     <= 1'b0;
      violation <= 1'b0;
      dataOut   <= '1;
    end else begin
      respValid <= strobe.load;
      grant     <= strobe.allow;
      violation <= strobe.load & ~strobe.allow;
      dataOut   <= strobe.allow ? picked : '1;
    end
  end

endmodule

// File: rtl/codeReadGate.sv
module codeReadGate
  import cpg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] intData,
  input  logic [DATA_W-1:0] extData,
  input  logic              optWrLock,
  input  logic              optWrRestrict,
  input  logic              chipErase,
  input  logic              progWrite,
  output logic              respValid,
  output logic              grant,
  output logic              violation,
  output logic [DATA_W-1:0] dataOut,
  output logic              flashBlank
);

  logic        lockBit;
  logic        restrictBit;
  gateStrobe_t strobe;

  cpg_option_store u_opts (
    .clk          (clk),
    .rst_n        (rst_n),
    .optWrLock    (optWrLock),
    .optWrRestrict(optWrRestrict),
    .chipErase    (chipErase),
    .progWrite    (progWrite),
    .lockBit      (lockBit),
    .restrictBit  (restrictBit),
    .flashBlank   (flashBlank)
  );

  cpg_policy #(.ADDR_W(ADDR_W), .INT_BYTES(INT_BYTES)) u_policy (
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .reqAddr    (reqAddr),
    .srcAddr    (srcAddr),
    .lockBit    (lockBit),
    .restrictBit(restrictBit),
    .strobe     (strobe)
  );

  cpg_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .intData  (intData),
    .extData  (extData),
    .respValid(respValid),
    .grant    (grant),
    .violation(violation),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/codeReadGate_chk.sv
module codeReadGate_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_BYTES = 16384
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [ADDR_W-1:0] srcAddr,
  input logic              respValid,
  input logic              grant,
  input logic              violation,
  input logic [DATA_W-1:0] dataOut,
  input logic              lockBit,
  input logic              chipErase,
  input logic              progWrite,
  input logic              flashBlank
);

  localparam logic [ADDR_W-1:0] INT_LIMIT = ADDR_W'(INT_BYTES);

  // R10: one-cycle response latency
  p_resp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!respValid && !violation));

  // R9: a violation always carries a denied, all-ones response
  p_deny_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> (respValid && !grant && dataOut == '1));

  // R2: fetches are never blocked
  p_fetch_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == 2'b00) |=> grant);

  // R4: locked part refuses programmer readback
  p_lock_denies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == 2'b10 && !lockBit) |=> violation);

  // R7: table reads issued from inside the region always pass
  p_inside_table_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == 2'b01 && srcAddr < INT_LIMIT) |=> grant);

  // R11: the lock returns to 1 only through an erase
  p_lock_only_erase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockBit) |-> $past(chipErase));

  // R12: blank indication clears only on a contents write
  p_blank_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flashBlank) |-> $past(progWrite));

endmodule

bind codeReadGate codeReadGate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_BYTES(INT_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqKind   (reqKind),
  .srcAddr   (srcAddr),
  .respValid (respValid),
  .grant     (grant),
  .violation (violation),
  .dataOut   (dataOut),
  .lockBit   (lockBit),
  .chipErase (chipErase),
  .progWrite (progWrite),
  .flashBlank(flashBlank)
);

// File: tb/codeReadGate_tb.sv
module codeReadGate_tb;

  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int INT_BYTES = 16384;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqKind = 2'b00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [ADDR_W-1:0] srcAddr = '0;
  logic [DATA_W-1:0] intData = '0;
  logic [DATA_W-1:0] extData = '0;
  logic              optWrLock = 1'b0;
  logic              optWrRestrict = 1'b0;
  logic              chipErase = 1'b0;
  logic              progWrite = 1'b0;
  logic              respValid, grant, violation, flashBlank;
  logic [DATA_W-1:0] dataOut;

  always #5 clk = ~clk;

  codeReadGate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_BYTES(INT_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .srcAddr(srcAddr), .intData(intData), .extData(extData),
    .optWrLock(optWrLock), .optWrRestrict(optWrRestrict), .chipErase(chipErase),
    .progWrite(progWrite), .respValid(respValid), .grant(grant),
    .violation(violation), .dataOut(dataOut), .flashBlank(flashBlank)
  );

  typedef struct {
    logic              g;
    logic [DATA_W-1:0] d;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  failures = 0;
  bit  monOn = 1'b0;
  bit  done = 1'b0;
  logic lockM = 1'b1;
  logic restrM = 1'b1;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // Driver: applies a request and pushes the expected response
  task automatic req(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                     input logic [ADDR_W-1:0] s, input string tag);
    expItem_t it;
    logic tInt, sInt, ok;
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; srcAddr = s;
    intData = a[7:0] ^ 8'h5A;
    extData = a[7:0] ^ 8'hA5;
    tInt = (a < INT_BYTES);
    sInt = (s < INT_BYTES);
    case (k)
      2'b00:   ok = 1'b1;
      2'b01:   ok = restrM | sInt | ~tInt;
      2'b10:   ok = lockM;
      default: ok = 1'b0;
    endcase
    it.g = ok;
    it.d = ok ? (tInt ? intData : extData) : 8'hFF;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: pops and compares each response
  always @(negedge clk) begin
    if (monOn && respValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected response", "respValid=1", "none");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(grant == e.g && violation == !e.g && dataOut == e.d, e.tag,
              $sformatf("g=%0b v=%0b d=%02h", grant, violation, dataOut),
              $sformatf("g=%0b v=%0b d=%02h", e.g, !e.g, e.d));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(respValid == 0 && grant == 0 && violation == 0 && dataOut == 8'hFF && flashBlank == 1,
          "R1 reset", $sformatf("%0b%0b%0b %02h %0b", respValid, grant, violation, dataOut, flashBlank),
          "000 ff 1");
    rst_n = 1'b1;
    @(negedge clk);
    check(respValid == 0 && violation == 0 && dataOut == 8'hFF && flashBlank == 1,
          "R1 after release", $sformatf("%0b%0b %02h %0b", respValid, violation, dataOut, flashBlank),
          "00 ff 1");
    monOn = 1'b1;

    req(2'b00, 16'h0000, 16'h0000, "R2 fetch 0000");
    req(2'b00, 16'h3FFF, 16'h3FFE, "R2 fetch 3fff int");
    req(2'b00, 16'h4000, 16'h4000, "R2 fetch 4000 ext");
    req(2'b10, 16'h0010, 16'h0000, "R3 prog int");
    req(2'b10, 16'h5000, 16'h0000, "R3 prog ext");
    req(2'b01, 16'h0020, 16'h8000, "R8 table ext->int open");
    req(2'b01, 16'h1234, 16'h0100, "R7 table int->int");
    req(2'b01, 16'h9000, 16'h0100, "R7 table int->ext");
    idle();

    // R11 program restriction bit to 0
    @(negedge clk); optWrRestrict = 1'b1;
    @(negedge clk); optWrRestrict = 1'b0; restrM = 1'b0;
    req(2'b01, 16'h0020, 16'h8000, "R5 table ext->int deny");
    req(2'b01, 16'h3FFF, 16'h4000, "R5 table ext->3fff deny");
    req(2'b01, 16'h4000, 16'h8000, "R6 table ext->ext");
    req(2'b01, 16'h0020, 16'h3FFF, "R7 table from 3fff");
    req(2'b01, 16'h0040, 16'h0000, "R7 table int->int restricted");
    req(2'b00, 16'h0020, 16'h8000, "R2 fetch under restriction");
    req(2'b11, 16'h0020, 16'h0000, "R9 reserved kind deny");
    idle();
    @(negedge clk);
    check(violation == 0 && respValid == 0, "R9 pulse ends / R10 idle",
          $sformatf("v=%0b rv=%0b", violation, respValid), "v=0 rv=0");

    // R12 contents write clears blank
    progWrite = 1'b1;
    @(negedge clk); progWrite = 1'b0;
    check(flashBlank == 0, "R12 blank cleared", $sformatf("%0b", flashBlank), "0");

    // R11 program lock bit to 0
    @(negedge clk); optWrLock = 1'b1;
    @(negedge clk); optWrLock = 1'b0; lockM = 1'b0;
    req(2'b10, 16'h0000, 16'h0000, "R4 prog 0000 locked");
    req(2'b10, 16'h3FFF, 16'h0000, "R4 prog 3fff locked");
    req(2'b10, 16'hFFFF, 16'h0000, "R4 prog ffff locked");
    req(2'b00, 16'h0100, 16'h0000, "R2 fetch while locked");
    idle();

    // R11 erase beats a simultaneous lock write; R12 blank set
    @(negedge clk); chipErase = 1'b1; optWrLock = 1'b1; progWrite = 1'b1;
    @(negedge clk); chipErase = 1'b0; optWrLock = 1'b0; progWrite = 1'b0;
    lockM = 1'b1; restrM = 1'b1;
    check(flashBlank == 1, "R12 erase sets blank", $sformatf("%0b", flashBlank), "1");
    req(2'b10, 16'h0010, 16'h0000, "R11 prog after erase");
    req(2'b01, 16'h0010, 16'hC000, "R11 table ext->int after erase");
    idle();
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R10 all responses seen", $sformatf("%0d", expQ.size()), "0");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule